// File: doc/BRIEF.md
# Pairwise Halving Vector Summer

This block adds up a vector of 2^K words of WIDTH bits each. The vector sits in a small staging store. The store can be filled one word at a time through an indexed write port, or all at once from a wide parallel input. A start pulse copies the staged words into a working buffer. The block then runs K reduction rounds in that buffer. Each round halves the number of active lanes. An active lane j (0-based) replaces entry j with the sum of entries 2j and 2j+1. When the rounds are over, entry 0 holds the total. It is moved into a result register and a done pulse is raised.

Every lane in a round reads the buffer as the previous round left it. New values only land at the clock edge that closes the round. The staging store is separate from the working buffer. The vector for the next job can therefore be written while the current job is still reducing.

Top module: `log_reduce_summer`

## Requirements
- R1: While and just after a synchronous active-high reset, `sum_o` is 0 and `done_o` is 0.
- R2: An indexed write with `wr_en` stores `wr_data` into slot `wr_idx` of the staging store. A parallel load with `ld_all` stores `ld_vec[i*WIDTH +: WIDTH]` into slot i for every i. When both are asserted in the same cycle, the parallel load wins.
- R3: A start that is accepted at a rising edge makes `done_o` high for exactly one cycle. That cycle follows the (K+2)-th rising edge, counting the accepting edge as the first: one copy step, K rounds and one store step. `done_o` is low in the cycle before it.
- R4: When `done_o` is high, `sum_o` equals the sum of all 2^K staged words, taken modulo 2^WIDTH. No overflow indication exists.
- R5: `start` is ignored from the accepting edge until the cycle in which `done_o` is high. A held or repeated start in that window produces no extra done pulse and does not change the result.
- R6: The staged vector is captured at the accepting edge. Writes to the staging store after that edge do not affect the running result, and they take effect for the next start.
- R7: `sum_o` holds its value between done pulses. The staging store keeps its contents, so a new start without new writes gives the same total again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reduction; accepted only when idle |
| wr_en | input | 1 | Indexed write strobe for the staging store |
| wr_idx | input | LOG2_LEN | Slot to write |
| wr_data | input | WIDTH | Word to write |
| ld_all | input | 1 | Parallel load of every staging slot |
| ld_vec | input | 2^LOG2_LEN*WIDTH | Packed vector, slot i at bits i*WIDTH upward |
| sum_o | output | WIDTH | Registered total |
| done_o | output | 1 | One-cycle pulse when `sum_o` is updated |

## Verification
The bench builds the block with LOG2_LEN=3 and WIDTH=8. Eight words of eight bits run through three halving rounds, so lane masks of four, two and one are all exercised. With a word width that narrow, totals such as eight copies of 255 wrap, which brings the modulo rule of R4 within reach. The short five-cycle job latency lets the bench hold start high across a whole job and rewrite staged slots mid-run, covering the ignore and snapshot rules.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_STORE = 2'd2
  } lrs_state_e;
endpackage

// File: rtl/lrs_vec_store.sv
module lrs_vec_store #(
  parameter int K = 3,
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [K-1:0]     wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             ld_all,
  input  logic [(1<<K)*W-1:0] ld_vec,
  output logic [(1<<K)*W-1:0] vec_o
);
  localparam int N = 1 << K;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (ld_all) begin
        slot_q <= ld_vec[g*W +: W];
      end else if (wr_en && (wr_idx == K'(g))) begin
        slot_q <= wr_data;
      end
    end
    assign vec_o[g*W +: W] = slot_q;
  end
endmodule

// File: rtl/lrs_lane.sv
module lrs_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] sum_o
);
  assign sum_o = lo_i + hi_i;
endmodule

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int K     = 3,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             load_o,
  output logic             round_en_o,
  output logic             store_o,
  output logic [LANES-1:0] lane_act_o
);
  localparam int N  = 2 * LANES;
  localparam int RW = $clog2(K + 1);

  lrs_state_e    state_q;
  logic [RW-1:0] round_q;

  assign load_o     = (state_q == ST_IDLE) && start;
  assign round_en_o = (state_q == ST_RUN);
  assign store_o    = (state_q == ST_STORE);

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      lane_act_o[j] = (state_q == ST_RUN) && ((N >> round_q) > j);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      round_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            round_q <= RW'(1);
          end
        end
        ST_RUN: begin
          if (round_q == RW'(K)) begin
            state_q <= ST_STORE;
          end else begin
            round_q <= round_q + RW'(1);
          end
        end
        ST_STORE: begin
          state_q <= ST_IDLE;
          round_q <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/log_reduce_summer.sv
module log_reduce_summer #(
  parameter int LOG2_LEN = 3,
  parameter int WIDTH    = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic                             wr_en,
  input  logic [LOG2_LEN-1:0]              wr_idx,
  input  logic [WIDTH-1:0]                 wr_data,
  input  logic                             ld_all,
  input  logic [(1<<LOG2_LEN)*WIDTH-1:0]   ld_vec,
  output logic [WIDTH-1:0]                 sum_o,
  output logic                             done_o
);
  localparam int N     = 1 << LOG2_LEN;
  localparam int LANES = N / 2;

  logic [N*WIDTH-1:0] staged;
  logic               load_b, round_en, store_en;
  logic [LANES-1:0]   lane_act;
  logic [WIDTH-1:0]   b_q [N];
  logic [WIDTH-1:0]   lane_sum [LANES];
  logic [WIDTH-1:0]   sum_q;
  logic               done_q;

  lrs_vec_store #(.K(LOG2_LEN), .W(WIDTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ld_all(ld_all), .ld_vec(ld_vec), .vec_o(staged)
  );

  lrs_ctrl #(.K(LOG2_LEN), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load_o(load_b),
    .round_en_o(round_en), .store_o(store_en), .lane_act_o(lane_act)
  );

  for (genvar g = 0; g < N; g++) begin : g_entry
    if (g < LANES) begin : g_lane
      lrs_lane #(.W(WIDTH)) u_lane (
        .lo_i(b_q[2*g]), .hi_i(b_q[2*g+1]), .sum_o(lane_sum[g])
      );
      always_ff @(posedge clk) begin
        if (rst) begin
          b_q[g] <= '0;
        end else if (load_b) begin
          b_q[g] <= staged[g*WIDTH +: WIDTH];
        end else if (round_en && lane_act[g]) begin
          b_q[g] <= lane_sum[g];
        end
      end
    end else begin : g_hold
      always_ff @(posedge clk) begin
        if (rst) begin
          b_q[g] <= '0;
        end else if (load_b) begin
          b_q[g] <= staged[g*WIDTH +: WIDTH];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= store_en;
      if (store_en) begin
        sum_q <= b_q[0];
      end
    end
  end

  assign sum_o  = sum_q;
  assign done_o = done_q;
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
  parameter int K = 3,
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         done_o,
  input logic [W-1:0] sum_o
);
  localparam int CW   = $clog2(K + 3) + 1;
  localparam int LAST = K + 2;

  logic          act_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q && (cnt_q == CW'(LAST))) begin
      if (start) begin
        cnt_q <= CW'(1);
      end else begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end
    end else if (act_q) begin
      cnt_q <= cnt_q + CW'(1);
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= CW'(1);
    end
  end

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_latency_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (act_q && (cnt_q == CW'(LAST))));

  p_done_due_r5: assert property (@(posedge clk) disable iff (rst)
    (act_q && (cnt_q == CW'(LAST))) |-> done_o);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> !done_o);

  p_sum_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(sum_o));
endmodule

bind log_reduce_summer lrs_checker #(.K(LOG2_LEN), .W(WIDTH)) u_lrs_checker (
  .clk(clk), .rst(rst), .start(start), .done_o(done_o), .sum_o(sum_o)
);

// File: tb/tb_log_reduce_summer.sv
module tb_log_reduce_summer;
  localparam int CLK_PERIOD = 10;
  localparam int K = 3;
  localparam int W = 8;
  localparam int N = 1 << K;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             wr_en = 1'b0;
  logic [K-1:0]     wr_idx = '0;
  logic [W-1:0]     wr_data = '0;
  logic             ld_all = 1'b0;
  logic [N*W-1:0]   ld_vec = '0;
  logic [W-1:0]     sum_o;
  logic             done_o;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  log_reduce_summer #(.LOG2_LEN(K), .WIDTH(W)) dut (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .ld_all(ld_all), .ld_vec(ld_vec),
    .sum_o(sum_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse (R4, R5)
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected done", 1, 0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(sum_o == e, "R4 total", int'(sum_o), int'(e));
      end
    end
  end

  // Driver: starts a job and checks the done timing (R3); noisy holds start high (R5)
  task automatic run_job(input logic [W-1:0] exp, input bit noisy);
    start = 1'b1;
    exp_q.push_back(exp);
    @(negedge clk);
    start = noisy;
    repeat (K) @(negedge clk);
    chk(done_o == 1'b0, "R3 done early", int'(done_o), 0);
    @(negedge clk);
    start = 1'b0;
    chk(done_o == 1'b1, "R3 done at K+2", int'(done_o), 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R3 single pulse", int'(done_o), 0);
  endtask

  task automatic par_load(input int base, input int step);
    for (int i = 0; i < N; i++) ld_vec[i*W +: W] = W'(base + i*step);
    ld_all = 1'b1;
    @(negedge clk);
    ld_all = 1'b0;
  endtask

  task automatic idx_write(input int idx, input int val);
    wr_en = 1'b1;
    wr_idx = K'(idx);
    wr_data = W'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sum_o == '0, "R1 sum in reset", int'(sum_o), 0);
    chk(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sum_o == '0 && done_o == 1'b0, "R1 after reset", int'(sum_o), 0);

    // R2/R4: parallel load 1..8 -> 36
    par_load(1, 1);
    run_job(8'd36, 1'b0);

    // R7: rerun without new writes gives same total; sum held in between
    repeat (3) @(negedge clk);
    chk(sum_o == 8'd36, "R7 sum held", int'(sum_o), 36);
    run_job(8'd36, 1'b0);

    // R4: wrap: eight words of 255 -> 2040 mod 256 = 248
    par_load(255, 0);
    run_job(8'd248, 1'b0);

    // R2: indexed writes on top of zeros: slot 0=3, slot 7=100, slot 4=20
    par_load(0, 0);
    idx_write(0, 3);
    idx_write(7, 100);
    idx_write(4, 20);
    run_job(8'd123, 1'b0);

    // R2: parallel load wins over indexed write in the same cycle
    for (int i = 0; i < N; i++) ld_vec[i*W +: W] = W'(2);
    ld_all = 1'b1;
    wr_en = 1'b1;
    wr_idx = 3'd5;
    wr_data = 8'd90;
    @(negedge clk);
    ld_all = 1'b0;
    wr_en = 1'b0;
    run_job(8'd16, 1'b0);

    // R5: start held high for the whole job -> one done, same total
    run_job(8'd16, 1'b1);
    repeat (4) @(negedge clk);
    chk(done_o == 1'b0 && sum_o == 8'd16, "R5 no extra job", int'(sum_o), 16);

    // R6: writes during a run do not change it; they apply to the next one
    start = 1'b1;
    exp_q.push_back(8'd16);
    @(negedge clk);
    start = 1'b0;
    wr_en = 1'b1;
    wr_idx = 3'd1;
    wr_data = 8'd52;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (K) @(negedge clk);
    chk(done_o == 1'b1 && sum_o == 8'd16, "R6 snapshot", int'(sum_o), 16);
    @(negedge clk);
    run_job(8'd66, 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule